// File: doc/BRIEF.md
# Packet Command Router with Configuration Register File

This block is the synchronous front end of an event-processing tile. A single 30-bit input channel with valid/ready handshake carries two kinds of traffic: configuration accesses to a 64-entry, 22-bit register file, and event (spike) packets. The two top bits of every packet select the kind. A read returns a response packet on the shared 30-bit output channel. A write updates the addressed entry. A spike is forwarded to the output only while the enable bit in entry 0 is set.

An optional loopback mode copies every accepted input packet unchanged to the output. The copy always leaves before any response that the same packet causes. The block holds at most one copy and one response at a time. It stops taking input while either is waiting, so no packet is ever lost.

Top module: `pkt_router`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, entry 0 holds all ones (4194303), and every other entry holds zero.
- R2: A packet with bit 29 = 1 and bit 28 = 0 is a read of the entry addressed by bits 5:0. The response has bits 29:28 = 00, the entry value in bits 27:6 and the address in bits 5:0. A read of entry 0 after reset therefore returns 0x0FFF_FFC0.
- R3: A packet with bits 29:28 = 11 writes bits 27:6 into the entry addressed by bits 5:0. A write produces no output packet apart from the loopback copy.
- R4: A packet with bits 29:28 = 00 is a spike. It is sent to the output unchanged when bit 0 of entry 0 is 1, and it is dropped when that bit is 0.
- R5: A packet with bits 29:28 = 01 is reserved. It is discarded, produces no output apart from the loopback copy, and changes no entry.
- R6: With loopback_en_i = 1, every accepted packet first appears unchanged on the output. Its read response or spike follows only after the copy has been taken.
- R7: in_ready_o is 0 whenever an output packet is waiting, and 1 otherwise.
- R8: While out_valid_o = 1 and out_ready_i = 0, out_valid_o stays 1 and out_data_o stays unchanged in the next cycle. At most one packet leaves per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loopback_en_i | input | 1 | Echo every accepted packet to the output |
| in_valid_i | input | 1 | Input packet valid |
| in_ready_o | output | 1 | Block can accept a packet |
| in_data_i | input | 30 | Input packet |
| out_valid_o | output | 1 | Output packet valid |
| out_ready_i | input | 1 | Downstream accepts the output packet |
| out_data_o | output | 30 | Output packet |

## Verification
A corrupted register entry shows up only when that entry is read back. The bench therefore writes distinct computed values to all 64 entries and reads each one back. It also reads entries after reserved packets to check that they are unchanged. A wrong enable bit shows at the next spike, as a missing packet or an extra packet on the output. A wrong pending flag shows in the same cycle as either a wrong in_ready_o level or a copy and response that leave in the wrong order. The bench checks ready and output data every time it holds backpressure.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;
  typedef enum logic [1:0] {
    KIND_SPIKE = 2'b00,
    KIND_RSVD  = 2'b01,
    KIND_READ  = 2'b10,
    KIND_WRITE = 2'b11
  } pkt_kind_e;
endpackage

// File: rtl/pkt_decode.sv
module pkt_decode
  import pkt_router_pkg::*;
#(
  parameter int PKT_W  = 30,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 22
) (
  input  logic [PKT_W-1:0]  pkt_i,
  output pkt_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    kind_o  = pkt_kind_e'(pkt_i[PKT_W-1 -: 2]);
    addr_o  = pkt_i[ADDR_W-1:0];
    wdata_o = pkt_i[ADDR_W +: DATA_W];
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 22,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              spike_en_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? '1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= RST_VAL;
      else if (we_i && waddr_i == ADDR_W'(g)) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o    = regs_q[raddr_i];
  assign spike_en_o = regs_q[0][0];
endmodule

// File: rtl/out_sequencer.sv
module out_sequencer #(
  parameter int PKT_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             echo_load_i,
  input  logic [PKT_W-1:0] echo_data_i,
  input  logic             resp_load_i,
  input  logic [PKT_W-1:0] resp_data_i,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [PKT_W-1:0] out_data_o
);
  logic             echo_q, resp_q;
  logic [PKT_W-1:0] echo_d_q, resp_d_q;
  logic             take;

  assign take = out_valid_o && out_ready_i;

  // loads only happen while idle, so no load collides with a take
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      echo_q   <= 1'b0;
      resp_q   <= 1'b0;
      echo_d_q <= '0;
      resp_d_q <= '0;
    end else begin
      if (accept_i) begin
        echo_q <= echo_load_i;
        resp_q <= resp_load_i;
        if (echo_load_i) echo_d_q <= echo_data_i;
        if (resp_load_i) resp_d_q <= resp_data_i;
      end else if (take) begin
        if (echo_q) echo_q <= 1'b0;
        else        resp_q <= 1'b0;
      end
    end
  end

  assign busy_o      = echo_q || resp_q;
  assign out_valid_o = busy_o;
  assign out_data_o  = echo_q ? echo_d_q : resp_d_q;
endmodule

// File: rtl/pkt_router.sv
module pkt_router
  import pkt_router_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 22,
  localparam int PKT_W = DATA_W + ADDR_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loopback_en_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PKT_W-1:0] in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PKT_W-1:0] out_data_o
);
  pkt_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              spike_en, accept, busy, resp_load;
  logic [PKT_W-1:0]  resp_data;

  pkt_decode #(.PKT_W(PKT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .pkt_i(in_data_i), .kind_o(kind), .addr_o(addr), .wdata_o(wdata)
  );

  assign in_ready_o = !busy;
  assign accept     = in_valid_i && in_ready_o;

  cfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (accept && kind == KIND_WRITE),
    .waddr_i   (addr),
    .wdata_i   (wdata),
    .raddr_i   (addr),
    .rdata_o   (rdata),
    .spike_en_o(spike_en)
  );

  always_comb begin
    resp_load = accept && (kind == KIND_READ || (kind == KIND_SPIKE && spike_en));
    resp_data = (kind == KIND_READ) ? {2'b00, rdata, addr} : in_data_i;
  end

  out_sequencer #(.PKT_W(PKT_W)) u_seq (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .echo_load_i(loopback_en_i),
    .echo_data_i(in_data_i),
    .resp_load_i(resp_load),
    .resp_data_i(resp_data),
    .out_ready_i,
    .busy_o     (busy),
    .out_valid_o,
    .out_data_o
  );
endmodule

// File: rtl/pkt_router_chk.sv
module pkt_router_chk #(
  parameter int PKT_W = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             loopback_en_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [PKT_W-1:0] in_data_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [PKT_W-1:0] out_data_o
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
  AST_READY_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R7
  AST_ECHO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && loopback_en_i |=> out_valid_o && out_data_o == $past(in_data_i)); // R6
  AST_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !loopback_en_i && in_data_i[PKT_W-1 -: 2] == 2'b11 |=> !out_valid_o); // R3
  AST_RSVD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !loopback_en_i && in_data_i[PKT_W-1 -: 2] == 2'b01 |=> !out_valid_o); // R5
  AST_READ_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !loopback_en_i && in_data_i[PKT_W-1 -: 2] == 2'b10 |=>
      out_valid_o && out_data_o[PKT_W-1 -: 2] == 2'b00 &&
      out_data_o[5:0] == $past(in_data_i[5:0])); // R2
  AST_SPIKE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !loopback_en_i && in_data_i[PKT_W-1 -: 2] == 2'b00 |=>
      !out_valid_o || out_data_o == $past(in_data_i)); // R4
endmodule

bind pkt_router pkt_router_chk #(.PKT_W(PKT_W)) u_chk (
  .clk_i, .rst_ni, .loopback_en_i, .in_valid_i, .in_ready_o, .in_data_i,
  .out_valid_o, .out_ready_i, .out_data_o
);

// File: tb/pkt_router_tb.sv
`timescale 1ns/1ps
module pkt_router_tb;
  localparam int W = 30;
  logic clk = 0, rst_n = 0, lb = 0, in_v = 0, in_r, out_v, out_r = 0;
  logic [W-1:0] in_d = '0, out_d;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .loopback_en_i(lb), .in_valid_i(in_v),
    .in_ready_o(in_r), .in_data_i(in_d), .out_valid_o(out_v),
    .out_ready_i(out_r), .out_data_o(out_d)
  );

  function automatic logic [21:0] val(int a);
    return 22'((a * 40503) ^ (a << 15) ^ 22'h15A5A5);
  endfunction

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] p);
    @(negedge clk);
    in_v = 1; in_d = p;
    while (!in_r) @(negedge clk);
    @(posedge clk); #1;
    in_v = 0;
  endtask

  task automatic recv(string req, logic [W-1:0] exp);
    @(negedge clk);
    chk(req, {out_v, out_d}, {1'b1, exp});
    out_r = 1;
    @(posedge clk); #1;
    out_r = 0;
  endtask

  task automatic idle(string req);
    @(negedge clk);
    chk(req, {out_v, in_r}, {1'b0, 1'b1});
  endtask

  function automatic logic [W-1:0] rd(int a);  return W'(32'h2000_0000 | a); endfunction
  function automatic logic [W-1:0] wr(int a, logic [21:0] d);
    return {2'b11, d, 6'(a)};
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    // R1 reset state
    idle("R1");
    // R6 loopback read of entry 0: echo then response (R2)
    lb = 1;
    send(rd(0));
    recv("R6", 30'h2000_0000);
    recv("R2", 30'h0FFF_FFC0);
    lb = 0;
    // R1 other entries zero
    for (int a = 1; a < 64; a += 9) begin send(rd(a)); recv("R1", {2'b00, 22'd0, 6'(a)}); end
    // R3 sweep writes, silent, then readback
    for (int a = 0; a < 64; a++) begin send(wr(a, val(a))); idle("R3"); end
    for (int a = 0; a < 64; a++) begin send(rd(a)); recv("R2", {2'b00, val(a), 6'(a)}); end
    // R4 spike dropped when enable clear
    send(wr(0, 22'h3FFFFE)); idle("R3");
    send(30'd8); idle("R4");
    send(wr(0, 22'd1));
    for (int s = 0; s < 64; s += 7) begin send(W'(s)); recv("R4", W'(s)); end
    send(30'h0ABC_DEF1 & 30'h0FFF_FFFF); recv("R4", 30'h0ABC_DEF1);
    // R5 reserved discarded, entry unchanged
    send({2'b01, 22'h3FFFFF, 6'd5}); idle("R5");
    send(rd(5)); recv("R5", {2'b00, val(5), 6'd5});
    lb = 1;
    send({2'b01, 22'h0, 6'd7}); recv("R5", {2'b01, 22'h0, 6'd7}); idle("R5");
    // R3 write with loopback: echo only
    send(wr(9, 22'h12345)); recv("R3", wr(9, 22'h12345)); idle("R3");
    // R7 / R8 backpressure during loopback read
    send(rd(9));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8", {out_v, out_d}, {1'b1, rd(9)});
      chk("R7", {30'd0, in_r}, 31'd0);
    end
    recv("R6", rd(9));
    @(negedge clk); chk("R7", {30'd0, in_r}, 31'd0);
    recv("R2", {2'b00, 22'h12345, 6'd9});
    // R6 spike with loopback: echo then forward
    send(30'd8); recv("R6", 30'd8); recv("R4", 30'd8); idle("R7");
    lb = 0;
    // R1 reset restores defaults
    rst_n = 0; #7 rst_n = 1;
    send(rd(0)); recv("R1", 30'h0FFF_FFC0);
    send(rd(9)); recv("R1", {2'b00, 22'd0, 6'd9});
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule